// File: doc/BRIEF.md
# Relative Branch Condition Resolver

This block takes the opcode byte and displacement byte of a two-byte relative branch from an 8-bit CPU. It also takes the address of that branch instruction and the six condition flags: overflow V, half-carry H, interrupt mask I, negative N, zero Z and carry C. From these it decides whether the branch is taken. It also produces the address the program counter moves to next.

Evaluation starts on a single-cycle start strobe. The taken flag, the group-valid flag and the next address are all registered. They change on the clock edge at which the strobe is sampled, and they hold their values until the next strobe.

The opcode map is fixed and irregular. It covers:
- unconditional always/never branches,
- unsigned lower and lower-or-same tests,
- signed less-than and less-or-equal tests,
- sign and zero tests,
- tests of the interrupt mask.

The flags are only read. No branch changes any condition flag.

Top module: `brc_resolver`

## Requirements
- R1: While reset is held, and after reset until the first sampled start, taken, grp_valid and next_pc all read 0.
- R2: When a branch is taken, next_pc equals pc + 2 + disp, where disp is taken as two's complement and sign-extended to 16 bits. The sum wraps modulo 65536.
- R3: When a branch is not taken, whatever the opcode, next_pc equals pc + 2 modulo 65536.
- R4: Opcode 0x20 is always taken. Opcode 0x21 is never taken, but it still reports grp_valid = 1.
- R5: Opcode 0x93 is taken when Z | (N ^ V) is 1. Opcode 0x91 is taken when N ^ V is 1.
- R6: Opcode 0x25 is taken when C = 1. Opcode 0x23 is taken when C | Z is 1.
- R7: Opcode 0x2C is taken when I = 0. Opcode 0x2D is taken when I = 1.
- R8: Opcode 0x2B is taken when N = 1, opcode 0x2A when N = 0, and opcode 0x26 when Z = 0.
- R9: Any opcode outside {0x20, 0x21, 0x23, 0x25, 0x26, 0x2A, 0x2B, 0x2C, 0x2D, 0x91, 0x93} gives grp_valid = 0 and taken = 0. The supported set gives grp_valid = 1.
- R10: Outputs update on the rising edge at which start is sampled high, from the inputs present at that edge. When start is low they keep their previous values.
- R11: The H flag has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Evaluate the presented branch on this edge |
| opcode | input | 8 | Branch opcode byte |
| disp | input | 8 | Signed displacement byte |
| pc | input | 16 | Address of the branch instruction |
| flag_v | input | 1 | Overflow flag |
| flag_h | input | 1 | Half-carry flag (unused by every condition) |
| flag_i | input | 1 | Interrupt mask flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| taken | output | 1 | Registered branch decision |
| grp_valid | output | 1 | Registered: opcode belongs to the relative-branch group |
| next_pc | output | 16 | Registered next program counter |

## Verification
A wrong decode entry or a mis-wired flag shows up as a wrong taken bit, and the next_pc is wrong with it. Both appear one edge after the strobe that presented the opcode. Because every supported opcode is swept over all 64 flag patterns, any flag dependence that should not be there, including one on H, appears within one pass. A fault in the sign extension or the carry out of the adder is visible only at a wrapping or negative displacement, so those cases are driven on purpose. A register that loads without a strobe shows up as an output that changes while start is low.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned DISP_W = 8;
  localparam int unsigned PC_W   = 16;
  localparam int unsigned INSN_LEN = 2;

  typedef enum logic [3:0] {
    COND_ALWAYS,
    COND_NEVER,
    COND_SLE,
    COND_SLT,
    COND_ULO,
    COND_ULS,
    COND_MASK_CLR,
    COND_MASK_SET,
    COND_NEG,
    COND_POS,
    COND_NZERO,
    COND_NONE
  } cond_e;

  typedef struct packed {
    logic v;
    logic i;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int unsigned OPW = OP_W
) (
  input  logic [OPW-1:0] opcode,
  output cond_e          cond,
  output logic           known
);
  always_comb begin
    cond  = COND_NONE;
    known = 1'b1;
    case (opcode)
      8'h20:   cond = COND_ALWAYS;
      8'h21:   cond = COND_NEVER;
      8'h93:   cond = COND_SLE;
      8'h91:   cond = COND_SLT;
      8'h25:   cond = COND_ULO;
      8'h23:   cond = COND_ULS;
      8'h2C:   cond = COND_MASK_CLR;
      8'h2D:   cond = COND_MASK_SET;
      8'h2B:   cond = COND_NEG;
      8'h2A:   cond = COND_POS;
      8'h26:   cond = COND_NZERO;
      default: begin
        cond  = COND_NONE;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  cond_e  cond,
  input  flags_t fl,
  output logic   hit
);
  logic sign_lt;

  assign sign_lt = fl.n ^ fl.v;

  always_comb begin
    case (cond)
      COND_ALWAYS:   hit = 1'b1;
      COND_NEVER:    hit = 1'b0;
      COND_SLE:      hit = fl.z | sign_lt;
      COND_SLT:      hit = sign_lt;
      COND_ULO:      hit = fl.c;
      COND_ULS:      hit = fl.c | fl.z;
      COND_MASK_CLR: hit = ~fl.i;
      COND_MASK_SET: hit = fl.i;
      COND_NEG:      hit = fl.n;
      COND_POS:      hit = ~fl.n;
      COND_NZERO:    hit = ~fl.z;
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int unsigned PCW = PC_W,
  parameter int unsigned DW  = DISP_W,
  parameter int unsigned LEN = INSN_LEN
) (
  input  logic [PCW-1:0] pc,
  input  logic [DW-1:0]  disp,
  input  logic           take,
  output logic [PCW-1:0] npc
);
  localparam int unsigned EXT_W = PCW - DW;
  localparam logic [PCW-1:0] LEN_V = PCW'(LEN);

  logic [PCW-1:0] seq_pc;
  logic [PCW-1:0] disp_x;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_x = {{EXT_W{disp[DW-1]}}, disp};
    end else begin : g_noext
      assign disp_x = disp[PCW-1:0];
    end
  endgenerate

  assign seq_pc = pc + LEN_V;
  assign npc    = take ? (seq_pc + disp_x) : seq_pc;
endmodule

// File: rtl/brc_resolver.sv
module brc_resolver
  import brc_pkg::*;
#(
  parameter int unsigned PCW = PC_W,
  parameter int unsigned DW  = DISP_W,
  parameter int unsigned OPW = OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  disp,
  input  logic [PCW-1:0] pc,
  input  logic           flag_v,
  input  logic           flag_h,
  input  logic           flag_i,
  input  logic           flag_n,
  input  logic           flag_z,
  input  logic           flag_c,
  output logic           taken,
  output logic           grp_valid,
  output logic [PCW-1:0] next_pc
);
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic unused_h;
  assign unused_h = flag_h;

  flags_t fl;
  assign fl = '{v: flag_v, i: flag_i, n: flag_n, z: flag_z, c: flag_c};

  cond_e          cond;
  logic           known;
  logic           hit;
  logic [PCW-1:0] npc;

  brc_decode #(.OPW(OPW)) u_dec (
    .opcode (opcode),
    .cond   (cond),
    .known  (known)
  );

  brc_cond_eval u_eval (
    .cond (cond),
    .fl   (fl),
    .hit  (hit)
  );

  brc_target #(.PCW(PCW), .DW(DW), .LEN(INSN_LEN)) u_tgt (
    .pc   (pc),
    .disp (disp),
    .take (hit),
    .npc  (npc)
  );

  logic           taken_d, valid_d;
  logic [PCW-1:0] npc_d;

  always_comb begin
    taken_d = taken;
    valid_d = grp_valid;
    npc_d   = next_pc;
    if (start) begin
      taken_d = hit & known;
      valid_d = known;
      npc_d   = npc;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      taken     <= 1'b0;
      grp_valid <= 1'b0;
      next_pc   <= '0;
    end else begin
      taken     <= taken_d;
      grp_valid <= valid_d;
      next_pc   <= npc_d;
    end
  end
endmodule

// File: rtl/brc_resolver_chk.sv
module brc_resolver_chk #(
  parameter int unsigned PCW = 16,
  parameter int unsigned DW  = 8,
  parameter int unsigned OPW = 8
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic           start,
  input logic [OPW-1:0] opcode,
  input logic [DW-1:0]  disp,
  input logic [PCW-1:0] pc,
  input logic           taken,
  input logic           grp_valid,
  input logic [PCW-1:0] next_pc
);
  // R2
  taken_target_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> (!taken || next_pc == $past(pc) + PCW'(2) + {{(PCW-DW){$past(disp[DW-1])}}, $past(disp)}));

  // R3
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> (taken || next_pc == $past(pc) + PCW'(2)));

  // R4
  always_op_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && opcode == 8'h20) |=> (taken && grp_valid));

  // R4
  never_op_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && opcode == 8'h21) |=> (!taken && grp_valid));

  // R9
  invalid_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !grp_valid |-> !taken);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !start |=> ($stable(taken) && $stable(grp_valid) && $stable(next_pc)));
endmodule

bind brc_resolver brc_resolver_chk #(.PCW(PCW), .DW(DW), .OPW(OPW)) i_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .start     (start),
  .opcode    (opcode),
  .disp      (disp),
  .pc        (pc),
  .taken     (taken),
  .grp_valid (grp_valid),
  .next_pc   (next_pc)
);

// File: tb/test_brc_resolver.sv
module test_brc_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode, disp;
  logic [15:0] pc;
  logic        fv, fh, fi, fn, fz, fc;
  logic        taken, grp_valid;
  logic [15:0] next_pc;

  int checks = 0;
  int errors = 0;

  logic        e_taken, e_valid;
  logic [15:0] e_pc;

  always #5 clk = ~clk;

  brc_resolver i_brc_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp), .pc(pc),
    .flag_v(fv), .flag_h(fh), .flag_i(fi), .flag_n(fn), .flag_z(fz), .flag_c(fc),
    .taken(taken), .grp_valid(grp_valid), .next_pc(next_pc)
  );

  function automatic bit is_member(input logic [7:0] op);
    return op inside {8'h20, 8'h21, 8'h23, 8'h25, 8'h26, 8'h2A, 8'h2B,
                      8'h2C, 8'h2D, 8'h91, 8'h93};
  endfunction

  function automatic bit ref_take(input logic [7:0] op, input logic [5:0] f);
    // f = {v,h,i,n,z,c}
    bit v = f[5], i = f[3], n = f[2], z = f[1], c = f[0];
    case (op)
      8'h20: return 1;
      8'h21: return 0;
      8'h93: return z | (n ^ v);
      8'h91: return n ^ v;
      8'h25: return c;
      8'h23: return c | z;
      8'h2C: return !i;
      8'h2D: return i;
      8'h2B: return n;
      8'h2A: return !n;
      8'h26: return !z;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h20, 8'h21: return "R4";
      8'h93, 8'h91: return "R5";
      8'h25, 8'h23: return "R6";
      8'h2C, 8'h2D: return "R7";
      8'h2B, 8'h2A, 8'h26: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (taken !== e_taken || grp_valid !== e_valid || next_pc !== e_pc) begin
      errors++;
      $display("FAIL %s: taken/valid/next_pc actual %b/%b/%h expected %b/%b/%h",
               tag, taken, grp_valid, next_pc, e_taken, e_valid, e_pc);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at the following negedge
  task automatic step(input bit s, input logic [7:0] op, input logic [7:0] d,
                      input logic [15:0] p, input logic [5:0] f, input string tag);
    int tgt;
    start = s; opcode = op; disp = d; pc = p;
    {fv, fh, fi, fn, fz, fc} = f;
    @(posedge clk);
    if (s) begin
      e_valid = is_member(op);
      e_taken = ref_take(op, f);
      tgt = int'(p) + 2;
      if (e_taken) tgt += int'($signed(d));
      e_pc = 16'(tgt & 16'hFFFF);
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [11] = '{8'h20, 8'h21, 8'h23, 8'h25, 8'h26, 8'h2A,
                             8'h2B, 8'h2C, 8'h2D, 8'h91, 8'h93};
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; disp = 8'h00; pc = 16'h0;
    {fv, fh, fi, fn, fz, fc} = 6'b0;
    e_taken = 1'b0; e_valid = 1'b0; e_pc = 16'h0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");

    // every supported opcode against every flag pattern (H included, R11)
    for (int k = 0; k < 11; k++) begin
      for (int f = 0; f < 64; f++) begin
        step(1'b1, ops[k], 8'(f * 7 + k), 16'(16'h4000 + f * 37 + k * 513), 6'(f), tag_of(ops[k]));
      end
    end

    // R11: toggling H alone leaves each result unchanged
    for (int k = 0; k < 11; k++) begin
      step(1'b1, ops[k], 8'h10, 16'h1234, 6'b010101, "R11");
      step(1'b1, ops[k], 8'h10, 16'h1234, 6'b000101, "R11");
    end

    // R9: full opcode sweep, flags chosen so most conditions would hold
    for (int op = 0; op < 256; op++) begin
      step(1'b1, 8'(op), 8'h33, 16'(op * 251), 6'b100011, is_member(8'(op)) ? "R9" : "R9");
    end

    // R2: wrap past the top and below zero
    step(1'b1, 8'h20, 8'h05, 16'hFFFF, 6'b0, "R2");
    step(1'b1, 8'h20, 8'h80, 16'h0001, 6'b0, "R2");
    step(1'b1, 8'h20, 8'hFE, 16'h8000, 6'b0, "R2");
    step(1'b1, 8'h20, 8'h7F, 16'hFF80, 6'b0, "R2");
    // R3: not-taken wrap and unsupported opcode
    step(1'b1, 8'h21, 8'h80, 16'hFFFE, 6'b0, "R3");
    step(1'b1, 8'h00, 8'h7F, 16'hFFFF, 6'b111111, "R3");

    // R10: hold while start is low, with inputs changing
    step(1'b1, 8'h26, 8'hF0, 16'h2000, 6'b0, "R10");
    for (int j = 0; j < 8; j++) begin
      step(1'b0, 8'(8'h20 + j), 8'(j * 29), 16'(j * 999), 6'(j * 9), "R10");
    end
    step(1'b1, 8'h26, 8'hF0, 16'h2000, 6'b000010, "R10");
    step(1'b0, 8'h20, 8'h01, 16'h0000, 6'b0, "R10");

    // R1: reset in mid-run clears outputs
    rst_n = 1'b0;
    e_taken = 1'b0; e_valid = 1'b0; e_pc = 16'h0;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule